// File: doc/BRIEF.md
# Registered Mixed-Sign 16x16 Multiplier

This block multiplies two 16-bit operands held in their own input registers and delivers the 32-bit result as two registered 16-bit halves: an upper half and a lower half. Each operand has its own signedness flag, captured with it. A flag of 1 reads the operand as two's complement and a flag of 0 reads it as unsigned. Signed-by-signed, unsigned-by-unsigned and mixed products all come out exact. Each register group has its own active-low load enable on the single clock: one for X, one for Y, and one for the product pair.

A round request is latched with the operands. It adds one unit at the top bit of the lower half. A layout input picks one of two layouts. The full layout gives the plain 32-bit product. The shifted layout is meant for signed fractional data. It moves the product left by one, and the freed top bit of the lower half then carries the sign. The shifted layout is accepted only when both latched flags are 1. In every other case the full layout is used. Output steering, bus drivers and transparent modes sit in a separate block.

Top module: `mmul_top`

## Requirements
- R1: While `rst` is high at a clock edge, every register clears: operands, flags, round request and both output halves become 0.
- R2: Each operand is read as two's complement when its latched flag is 1 and as unsigned when it is 0. The two flags act independently, so mixed products are exact modulo 2^32.
- R3: An operand and its flag load at a rising edge only while that operand's enable (`x_ld_n` / `y_ld_n`) is 0. While the enable is 1, the operand and its flag keep their value.
- R4: The round request loads from `rnd` at any edge where either operand enable is 0. When both are 1, it holds.
- R5: In the full layout (`fmt_full` = 1), `prod_hi` = R[31:16] and `prod_lo` = R[15:0], where R is the rounded product modulo 2^32.
- R6: In the shifted layout (`fmt_full` = 0, both flags 1), `prod_hi` = R[30:15], `prod_lo[15]` = R[31], and `prod_lo[14:0]` = R[14:0].
- R7: A latched round request adds 2^15 to the raw product in the full layout and 2^14 in the shifted layout. The addition is modulo 2^32 and happens before the layout is applied.
- R8: When either latched flag is 0, `fmt_full` = 0 has no effect and the outputs follow the full layout.
- R9: Both output halves load only at edges where `prod_ld_n` is 0. Otherwise they hold.
- R10: Squaring 0x8000 with both flags 1 overflows. The full layout gives 0x4000/0x0000. The shifted layout gives 0x8000/0x0000, which is -1 as a signed fraction.
- R11: The output registers sample the operands as they stood before the same edge. An operand loaded at edge k reaches the outputs at the first edge after k where `prod_ld_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 16 | Operand X |
| x_sgn | input | 1 | X signedness flag (1 = two's complement) |
| x_ld_n | input | 1 | X register load enable, active low |
| y_in | input | 16 | Operand Y |
| y_sgn | input | 1 | Y signedness flag (1 = two's complement) |
| y_ld_n | input | 1 | Y register load enable, active low |
| rnd | input | 1 | Round request, latched with operand loads |
| fmt_full | input | 1 | 1 = full product, 0 = shifted product |
| prod_ld_n | input | 1 | Output register load enable, active low |
| prod_hi | output | 16 | Registered upper half |
| prod_lo | output | 16 | Registered lower half |

## Verification
A result is due one clock after its operands are latched, at the edge where `prod_ld_n` is low. The layout input is combinational into that same edge. The bench loads the operands at one edge and opens the output enable for the next edge. It then compares the outputs in the low phase after that second edge, and never earlier. The latency and hold checks count edges on the same basis. They expect the old product right after a fresh operand load and the new product one edge later.

// File: rtl/mmul_pkg.sv
package mmul_pkg;
  localparam int unsigned MMUL_OPW = 16;

  // Layout selector handed from the control logic to the formatter.
  typedef enum logic {
    FMT_FULL  = 1'b0,
    FMT_SHIFT = 1'b1
  } fmt_e;

  // Effective layout: shifting is only honoured for signed x signed.
  function automatic fmt_e pick_fmt(input logic full_req, input logic sa, input logic sb);
    return (!full_req && sa && sb) ? FMT_SHIFT : FMT_FULL;
  endfunction
endpackage

// File: rtl/mmul_in_reg.sv
module mmul_in_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  input  logic         sgn,
  output logic [W-1:0] q,
  output logic         sgn_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      sgn_q <= 1'b0;
    end else if (!ld_n) begin
      q     <= d;
      sgn_q <= sgn;
    end
  end
endmodule

// File: rtl/mmul_mult.sv
module mmul_mult #(
  parameter int unsigned OPW = 16
) (
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  input  logic             sa,
  input  logic             sb,
  input  logic             rnd,
  input  mmul_pkg::fmt_e   mode,
  output logic [2*OPW-1:0] prod
);
  localparam int unsigned PW = 2 * OPW;
  localparam logic [PW-1:0] ONE      = {{(PW-1){1'b0}}, 1'b1};
  localparam logic [PW-1:0] RW_FULL  = ONE << (OPW - 1);
  localparam logic [PW-1:0] RW_SHIFT = ONE << (OPW - 2);

  logic [PW-1:0] a_x, b_x, rnd_add;

  // Extend each operand to product width by its own signedness; the low
  // PW bits of the product are exact for every sign combination.
  always_comb begin
    a_x = {{OPW{sa & a[OPW-1]}}, a};
    b_x = {{OPW{sb & b[OPW-1]}}, b};
    if (!rnd)                           rnd_add = '0;
    else if (mode == mmul_pkg::FMT_SHIFT) rnd_add = RW_SHIFT;
    else                                rnd_add = RW_FULL;
    prod = a_x * b_x + rnd_add;
  end
endmodule

// File: rtl/mmul_fmt.sv
module mmul_fmt #(
  parameter int unsigned OPW = 16
) (
  input  logic [2*OPW-1:0] prod,
  input  mmul_pkg::fmt_e   mode,
  output logic [OPW-1:0]   hi,
  output logic [OPW-1:0]   lo
);
  localparam int unsigned PW = 2 * OPW;

  always_comb begin
    if (mode == mmul_pkg::FMT_SHIFT) begin
      hi = prod[PW-2:OPW-1];
      lo = {prod[PW-1], prod[OPW-2:0]};
    end else begin
      hi = prod[PW-1:OPW];
      lo = prod[OPW-1:0];
    end
  end
endmodule

// File: rtl/mmul_out_reg.sv
module mmul_out_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_n,
  input  logic [W-1:0] d_hi,
  input  logic [W-1:0] d_lo,
  output logic [W-1:0] q_hi,
  output logic [W-1:0] q_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_hi <= '0;
      q_lo <= '0;
    end else if (!ld_n) begin
      q_hi <= d_hi;
      q_lo <= d_lo;
    end
  end
endmodule

// File: rtl/mmul_top.sv
module mmul_top #(
  parameter int unsigned OPW = mmul_pkg::MMUL_OPW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] x_in,
  input  logic           x_sgn,
  input  logic           x_ld_n,
  input  logic [OPW-1:0] y_in,
  input  logic           y_sgn,
  input  logic           y_ld_n,
  input  logic           rnd,
  input  logic           fmt_full,
  input  logic           prod_ld_n,
  output logic [OPW-1:0] prod_hi,
  output logic [OPW-1:0] prod_lo
);
  localparam int unsigned PW   = 2 * OPW;
  localparam int unsigned NOPD = 2;

  logic [NOPD-1:0][OPW-1:0] opd_d, opd_q;
  logic [NOPD-1:0]          sgn_d, sgn_q, ld_n_v;
  logic [OPW-1:0]           x_q, y_q, f_hi, f_lo;
  logic                     x_sgn_q, y_sgn_q, rnd_q;
  logic [PW-1:0]            prod_rnd;
  mmul_pkg::fmt_e           mode;

  assign opd_d  = {y_in, x_in};
  assign sgn_d  = {y_sgn, x_sgn};
  assign ld_n_v = {y_ld_n, x_ld_n};

  for (genvar i = 0; i < NOPD; i++) begin : g_opd
    mmul_in_reg #(.W(OPW)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .ld_n  (ld_n_v[i]),
      .d     (opd_d[i]),
      .sgn   (sgn_d[i]),
      .q     (opd_q[i]),
      .sgn_q (sgn_q[i])
    );
  end

  assign x_q     = opd_q[0];
  assign y_q     = opd_q[1];
  assign x_sgn_q = sgn_q[0];
  assign y_sgn_q = sgn_q[1];

  // Round request follows any operand load.
  always_ff @(posedge clk) begin
    if (rst)                   rnd_q <= 1'b0;
    else if (!x_ld_n || !y_ld_n) rnd_q <= rnd;
  end

  assign mode = mmul_pkg::pick_fmt(fmt_full, x_sgn_q, y_sgn_q);

  mmul_mult #(.OPW(OPW)) u_mult (
    .a    (x_q),
    .b    (y_q),
    .sa   (x_sgn_q),
    .sb   (y_sgn_q),
    .rnd  (rnd_q),
    .mode (mode),
    .prod (prod_rnd)
  );

  mmul_fmt #(.OPW(OPW)) u_fmt (
    .prod (prod_rnd),
    .mode (mode),
    .hi   (f_hi),
    .lo   (f_lo)
  );

  mmul_out_reg #(.W(OPW)) u_out (
    .clk  (clk),
    .rst  (rst),
    .ld_n (prod_ld_n),
    .d_hi (f_hi),
    .d_lo (f_lo),
    .q_hi (prod_hi),
    .q_lo (prod_lo)
  );
endmodule

// File: rtl/mmul_chk.sv
module mmul_chk #(
  parameter int unsigned OPW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             x_ld_n,
  input logic             y_ld_n,
  input logic             prod_ld_n,
  input logic             rnd,
  input logic             rnd_q,
  input logic [OPW-1:0]   x_q,
  input logic [OPW-1:0]   y_q,
  input logic             x_sgn_q,
  input logic             y_sgn_q,
  input logic [2*OPW-1:0] prod_rnd,
  input logic [OPW-1:0]   prod_hi,
  input logic [OPW-1:0]   prod_lo
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (prod_hi == '0 && prod_lo == '0 && rnd_q == 1'b0));

  // R3
  a_r3_x_hold: assert property (@(posedge clk) disable iff (rst)
    x_ld_n |=> ($stable(x_q) && $stable(x_sgn_q)));

  // R3
  a_r3_y_hold: assert property (@(posedge clk) disable iff (rst)
    y_ld_n |=> ($stable(y_q) && $stable(y_sgn_q)));

  // R4
  a_r4_rnd_load: assert property (@(posedge clk) disable iff (rst)
    (!x_ld_n || !y_ld_n) |=> (rnd_q == $past(rnd)));

  // R4
  a_r4_rnd_hold: assert property (@(posedge clk) disable iff (rst)
    (x_ld_n && y_ld_n) |=> $stable(rnd_q));

  // R8
  a_r8_full_when_unsigned: assert property (@(posedge clk) disable iff (rst)
    (!prod_ld_n && !(x_sgn_q && y_sgn_q)) |=> ({prod_hi, prod_lo} == $past(prod_rnd)));

  // R9
  a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
    prod_ld_n |=> ($stable(prod_hi) && $stable(prod_lo)));
endmodule

bind mmul_top mmul_chk #(.OPW(OPW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .x_ld_n    (x_ld_n),
  .y_ld_n    (y_ld_n),
  .prod_ld_n (prod_ld_n),
  .rnd       (rnd),
  .rnd_q     (rnd_q),
  .x_q       (x_q),
  .y_q       (y_q),
  .x_sgn_q   (x_sgn_q),
  .y_sgn_q   (y_sgn_q),
  .prod_rnd  (prod_rnd),
  .prod_hi   (prod_hi),
  .prod_lo   (prod_lo)
);

// File: tb/mmul_top_tb.sv
module mmul_top_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] x_in = '0, y_in = '0;
  logic        x_sgn = 1'b0, y_sgn = 1'b0, x_ld_n = 1'b1, y_ld_n = 1'b1;
  logic        rnd = 1'b0, fmt_full = 1'b1, prod_ld_n = 1'b1;
  logic [15:0] prod_hi, prod_lo;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  mmul_top u_dut (
    .clk(clk), .rst(rst),
    .x_in(x_in), .x_sgn(x_sgn), .x_ld_n(x_ld_n),
    .y_in(y_in), .y_sgn(y_sgn), .y_ld_n(y_ld_n),
    .rnd(rnd), .fmt_full(fmt_full), .prod_ld_n(prod_ld_n),
    .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  // Reference from the requirements: exact 64-bit product, modulo 2^32,
  // round weight by layout, then the layout itself.
  function automatic logic [31:0] ref_out(input logic [15:0] x, input logic [15:0] y,
                                          input logic sx, input logic sy,
                                          input logic r, input logic full);
    longint xs, ys, p;
    logic [31:0] rr;
    logic shift;
    xs = sx ? longint'($signed(x)) : longint'({48'b0, x});
    ys = sy ? longint'($signed(y)) : longint'({48'b0, y});
    shift = !full && sx && sy;
    p = xs * ys;
    if (r) p = p + (shift ? 64'sd16384 : 64'sd32768);
    rr = p[31:0];
    if (shift) return {rr[30:15], rr[31], rr[14:0]};
    return rr;
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    n_chk++;
    if ({prod_hi, prod_lo} !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h_%h expected %h_%h", tag, prod_hi, prod_lo, exp[31:16], exp[15:0]);
    end
  endtask

  // Load both operands at one edge, the product at the next, check after it.
  task automatic run_vec(input logic [15:0] x, input logic [15:0] y,
                         input logic sx, input logic sy, input logic r, input logic full,
                         input string tag);
    @(negedge clk);
    x_in = x; y_in = y; x_sgn = sx; y_sgn = sy; rnd = r;
    x_ld_n = 1'b0; y_ld_n = 1'b0; prod_ld_n = 1'b1;
    @(negedge clk);
    x_ld_n = 1'b1; y_ld_n = 1'b1; prod_ld_n = 1'b0; fmt_full = full;
    @(negedge clk);
    prod_ld_n = 1'b1;
    check(tag, ref_out(x, y, sx, sy, r, full));
  endtask

  logic [15:0] pats [8];

  initial begin
    pats[0] = 16'h0000; pats[1] = 16'h0001; pats[2] = 16'h7FFF; pats[3] = 16'h8000;
    pats[4] = 16'hFFFF; pats[5] = 16'h1234; pats[6] = 16'hA5C3; pats[7] = 16'h4000;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", 32'h0);

    // Sweep of patterns x patterns x flags x round x layout
    for (int m = 0; m < 16; m++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic sx, sy, r, f;
          string tag;
          sx = m[0]; sy = m[1]; r = m[2]; f = m[3];
          if (sx && sy && pats[i] == 16'h8000 && pats[j] == 16'h8000 && !r) tag = "R10 min squared";
          else if (r)              tag = "R7 rounding";
          else if (!f && !(sx && sy)) tag = "R8 shift ignored";
          else if (!f)             tag = "R6 shifted layout";
          else if (sx != sy)       tag = "R2 mixed sign";
          else                     tag = "R5 full layout";
          run_vec(pats[i], pats[j], sx, sy, r, f, tag);
        end
      end
    end

    // R10 explicit values
    run_vec(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b1, "R10 full");
    check("R10 full literal", 32'h4000_0000);
    run_vec(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, "R10 shifted");
    check("R10 shifted literal", 32'h8000_0000);

    // R3: X enable high, new X data ignored
    run_vec(16'h0003, 16'h0005, 1'b0, 1'b0, 1'b0, 1'b1, "R3 base");
    @(negedge clk);
    x_in = 16'h0100; x_sgn = 1'b1; x_ld_n = 1'b1; y_ld_n = 1'b1; prod_ld_n = 1'b1;
    @(negedge clk);
    prod_ld_n = 1'b0;
    @(negedge clk);
    prod_ld_n = 1'b1;
    check("R3 X held", 32'd15);

    // R4: round input ignored while both enables high
    @(negedge clk);
    rnd = 1'b1; prod_ld_n = 1'b0;
    @(negedge clk);
    prod_ld_n = 1'b1;
    check("R4 round held", 32'd15);
    // R4: loading Y only also captures the round request
    @(negedge clk);
    y_in = 16'h0005; y_ld_n = 1'b0; rnd = 1'b1;
    @(negedge clk);
    y_ld_n = 1'b1; rnd = 1'b0; prod_ld_n = 1'b0;
    @(negedge clk);
    prod_ld_n = 1'b1;
    check("R4 round via Y load", 32'd15 + 32'd32768);

    // R9: product enable high keeps outputs while operands change
    @(negedge clk);
    x_in = 16'h0007; x_sgn = 1'b0; x_ld_n = 1'b0; rnd = 1'b0;
    @(negedge clk);
    x_ld_n = 1'b1;
    @(negedge clk);
    check("R9 outputs held", 32'd15 + 32'd32768);

    // R11: with product enable open, new X shows one edge later
    @(negedge clk);
    prod_ld_n = 1'b0;
    @(negedge clk);
    check("R11 settle", 32'd35);
    x_in = 16'h0009; x_ld_n = 1'b0;
    @(negedge clk);
    x_ld_n = 1'b1;
    check("R11 old product at load edge", 32'd35);
    @(negedge clk);
    prod_ld_n = 1'b1;
    check("R11 new product next edge", 32'd45);

    // R1: reset mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-run", 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule